// File: doc/BRIEF.md
# Serial-In Latched Sink Driver Core

This block is the logic core of an eight-channel power sink driver that is loaded over a serial link. A bit stream enters a chain of shift stages on rising edges of a shift clock. A separate strobe input then copies the whole chain into a bank of holding latches in one step, so the channel outputs change together rather than ripple as bits arrive. Each channel output is a sink-enable bit: 1 means that channel's open-drain switch conducts.

The last shift stage is also presented on a serial output, so several devices can be chained and loaded from one serial stream. An active-high blank input switches every channel off without disturbing the latches, and releasing it restores the latched pattern. An active-low clear input asynchronously empties both the shift chain and the latches.

Top module: `sink_driver_core`

## Requirements
- R1: On each rising edge of shift_clk_i, sdata_i is captured into stage 0 and every other stage n takes the previous value of stage n-1.
- R2: sdata_o always equals the last stage (stage 7). When a byte is shifted in with its bit 7 first, each further shift edge presents the next lower bit of that byte on sdata_o.
- R3: On a rising edge of strobe_i, latch bit n takes the value of shift stage n. Shifting without a strobe leaves the latches, and therefore sink_on_o, unchanged.
- R4: While blank_i is 1, sink_on_o is 8'h00 whatever the latches hold.
- R5: blank_i never alters the latches. When blank_i returns to 0, sink_on_o again shows the latched pattern without a new strobe.
- R6: While rst_ni is 0, the shift stages and the latches are zero, so sink_on_o is 8'h00 and sdata_o is 0 at once, without any clock edge. A strobe after a clear therefore latches zeros.
- R7: With blank_i at 0, sink_on_o[n] is 1 exactly when latch bit n is 1. Bit n of the byte shifted in with bit 7 first appears on channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift clock; serial data moves on its rising edge |
| strobe_i | input | 1 | Latch strobe; the chain is copied into the latches on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low clear of the shift stages and the latches |
| sdata_i | input | 1 | Serial data into stage 0 |
| blank_i | input | 1 | Active-high blank; forces every channel off |
| sdata_o | output | 1 | Serial data out from the last stage, for chaining |
| sink_on_o | output | 8 | Per-channel sink enable; bit n is channel n, 1 means conducting |

## Verification
No result waits for a later edge. sdata_o settles right after the shift edge that moves data into the last stage. sink_on_o settles right after the strobe edge. Changes on blank_i and rst_ni reach the outputs combinationally or asynchronously, with no clock at all. The bench gives each edge a 2 ns high phase, samples 1 ns after the falling edge, and after a change on blank_i or rst_ni samples 1 ns later with no clock edge in between. The delayed-value assertions are armed only after one clean shift edge since the last clear.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;
  localparam int unsigned SDRV_NUM_CH = 8;
  localparam int unsigned SDRV_MIN_CH = 2;
endpackage

// File: rtl/sdrv_shift_reg.sv
module sdrv_shift_reg #(
  parameter int unsigned NUM_CH = sdrv_pkg::SDRV_NUM_CH
) (
  input  logic              shift_clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  output logic [NUM_CH-1:0] stage_o
);
  logic [NUM_CH-1:0] stage_q;

  always_ff @(posedge shift_clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[NUM_CH-2:0], sdata_i};
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/sdrv_latch_bank.sv
module sdrv_latch_bank #(
  parameter int unsigned NUM_CH = sdrv_pkg::SDRV_NUM_CH
) (
  input  logic              strobe_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] d_i,
  output logic [NUM_CH-1:0] q_o
);
  logic [NUM_CH-1:0] q_q;

  always_ff @(posedge strobe_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sdrv_out_gate.sv
module sdrv_out_gate #(
  parameter int unsigned NUM_CH = sdrv_pkg::SDRV_NUM_CH
) (
  input  logic [NUM_CH-1:0] latch_i,
  input  logic              blank_i,
  output logic [NUM_CH-1:0] sink_on_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign sink_on_o[g] = latch_i[g] & ~blank_i;
  end
endmodule

// File: rtl/sink_driver_core.sv
module sink_driver_core #(
  parameter int unsigned NUM_CH = sdrv_pkg::SDRV_NUM_CH
) (
  input  logic              shift_clk_i,
  input  logic              strobe_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              blank_i,
  output logic              sdata_o,
  output logic [NUM_CH-1:0] sink_on_o
);
  localparam int unsigned LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] stage;
  logic [NUM_CH-1:0] latch;

  sdrv_shift_reg #(.NUM_CH(NUM_CH)) u_shift (
    .shift_clk_i(shift_clk_i),
    .rst_ni     (rst_ni),
    .sdata_i    (sdata_i),
    .stage_o    (stage)
  );

  sdrv_latch_bank #(.NUM_CH(NUM_CH)) u_latch (
    .strobe_i(strobe_i),
    .rst_ni  (rst_ni),
    .d_i     (stage),
    .q_o     (latch)
  );

  sdrv_out_gate #(.NUM_CH(NUM_CH)) u_gate (
    .latch_i  (latch),
    .blank_i  (blank_i),
    .sink_on_o(sink_on_o)
  );

  assign sdata_o = stage[LAST];

  // Set by the first shift edge after a clear; gates the $past checks.
  logic armed_q;
  always_ff @(posedge shift_clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  a_r1_shift_in: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    armed_q |-> stage[0] == $past(sdata_i));

  a_r2_serial_out: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    armed_q |-> sdata_o == $past(stage[LAST-1]));

  always_ff @(posedge shift_clk_i) begin
    if (!rst_ni) begin
      a_r6_clear: assert (sink_on_o == '0 && sdata_o == 1'b0 && latch == '0);
    end else if (blank_i) begin
      a_r4_blank: assert (sink_on_o == '0);
    end else begin
      a_r7_follow: assert (sink_on_o == latch);
    end
  end

  // R5: releasing blank restores the held pattern with no strobe edge.
  a_r5_unblank: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    (!blank_i && !strobe_i) |-> sink_on_o == latch);
endmodule

// File: tb/sink_driver_core_test.sv
`timescale 1ns/1ps
module sink_driver_core_test;
  logic       clk = 1'b0;
  logic       shift_clk_i = 1'b0;
  logic       strobe_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sdata_i = 1'b0;
  logic       blank_i = 1'b0;
  logic       sdata_o;
  logic [7:0] sink_on_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sink_driver_core uut (
    .shift_clk_i(shift_clk_i),
    .strobe_i   (strobe_i),
    .rst_ni     (rst_ni),
    .sdata_i    (sdata_i),
    .blank_i    (blank_i),
    .sdata_o    (sdata_o),
    .sink_on_o  (sink_on_o)
  );

  // {pattern[7:0], blank}
  localparam logic [8:0] VEC [6] = '{
    {8'hA5, 1'b0}, {8'h3C, 1'b0}, {8'hFF, 1'b1},
    {8'h00, 1'b0}, {8'h81, 1'b0}, {8'h5A, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata_i = b;
    #1 shift_clk_i = 1'b1;
    #2 shift_clk_i = 1'b0;
    #1;
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic strobe;
    #1 strobe_i = 1'b1;
    #2 strobe_i = 1'b0;
    #1;
  endtask

  initial begin
    #5;
    chk("R6 reset sink", sink_on_o, 8'h00);
    chk("R6 reset sdata", {7'd0, sdata_o}, 8'h00);
    rst_ni = 1'b1;
    #3;

    for (int v = 0; v < 6; v++) begin
      logic [7:0] pat;
      pat = VEC[v][8:1];
      blank_i = VEC[v][0];
      shift_byte(pat);
      chk("R2 last stage", {7'd0, sdata_o}, {7'd0, pat[7]});
      strobe();
      chk(VEC[v][0] ? "R4 blanked" : "R7 channel map", sink_on_o,
          VEC[v][0] ? 8'h00 : pat);
    end

    // R5: unblank restores 5A without a strobe.
    blank_i = 1'b0;
    #1 chk("R5 unblank restore", sink_on_o, 8'h5A);
    blank_i = 1'b1;
    #1 chk("R4 blank again", sink_on_o, 8'h00);
    blank_i = 1'b0;
    #1 chk("R5 latch kept", sink_on_o, 8'h5A);

    // R1/R2: cascade stream; stage7 shows lower bits in turn.
    shift_byte(8'hC6);
    for (int j = 1; j < 8; j++) begin
      logic [7:0] c;
      c = 8'hC6;
      shift_bit(1'b0);
      chk("R1 R2 cascade out", {7'd0, sdata_o}, {7'd0, c[7-j]});
    end
    // Stage contents now 8'h00 apart from the shifted-in zeros: shift one 1.
    shift_bit(1'b1);
    strobe();
    chk("R1 stage0 capture", sink_on_o, 8'h01);

    // R3: shifting without strobe leaves outputs.
    shift_byte(8'hF0);
    chk("R3 hold no strobe", sink_on_o, 8'h01);
    strobe();
    chk("R3 strobe capture", sink_on_o, 8'hF0);

    // R6: async clear mid-run.
    shift_byte(8'h99);
    rst_ni = 1'b0;
    #1;
    chk("R6 async clear sink", sink_on_o, 8'h00);
    chk("R6 async clear sdata", {7'd0, sdata_o}, 8'h00);
    #2 rst_ni = 1'b1;
    #2;
    strobe();
    chk("R6 chain cleared", sink_on_o, 8'h00);
    shift_byte(8'h42);
    strobe();
    chk("R7 after clear", sink_on_o, 8'h42);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule